// File: doc/BRIEF.md
# Banked Multi-Port Scratchpad with Read-Modify-Write Sequencing

This block is a shared on-chip scratchpad made of independently addressed banks, each holding 128-bit words. Several request ports reach every bank through a crossbar. Each port is shared by a small group of clients behind a round-robin multiplexer. A client presents a valid/ready request with a byte address, write data, byte enables, a compare word and an opcode. Each bank serves at most one port per cycle. A port that loses arbitration holds its request until a later cycle.

Every accepted request produces one response on its port one cycle later. The response carries the data, the identity of the client and an error flag. Plain reads and writes, and reads that keep only some bytes, use a bank for a single cycle. Sub-word writes, swaps and compare-and-swap run as read-modify-write inside the bank. Each of these claims its port and its bank for a fixed window of five cycles.

Top module: `sp_banked_scratch`

## Requirements
- R1: The bank index is byte-address bits [7:4] and the row is bits [11:8], so consecutive 128-bit words fall in different banks, and two addresses in one bank but in different rows hold separate words.
- R2: In any cycle a bank accepts a request from at most one port. A port that loses keeps ready low and is accepted in a later cycle.
- R3: On each port at most one client is accepted per cycle. The clients of a port take turns in round-robin order that starts after the last client accepted.
- R4: Each bank picks among competing ports in round-robin order that starts after the last port it accepted, not by fixed priority.
- R5: A response (rspValid high, rspClient equal to the client's index within its port) appears exactly one cycle after a request is accepted.
- R6: Opcode 0 (read) returns the whole stored word. Opcode 1 (write) stores all 16 bytes whatever the byte enables are, and returns zero data.
- R7: Opcode 2 (narrow read) returns the stored word with every byte whose enable bit is 0 forced to zero. It uses the port for only one cycle.
- R8: Opcode 3 (narrow write) replaces only the bytes whose enable bit is 1 and returns zero data. Its port and its bank accept nothing in the four cycles after its acceptance, and a read accepted afterwards sees the merged word.
- R9: Opcode 4 (swap) returns the old word and stores the write data, with the same five-cycle hold as R8.
- R10: Opcode 5 (compare-and-swap) returns the old word and stores the write data only when the old word equals the compare word.
- R11: A request whose row is not below the bank depth (4 by default) is accepted at once and answered with rspErr high and zero data. It changes no stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | PORTS*CLIENTS | Request valid per client (client c of port p at index p*CLIENTS+c) |
| reqReady | output | PORTS*CLIENTS | Request accepted this cycle, per client |
| reqOp | input | PORTS*CLIENTS*3 | Opcode per client |
| reqAddr | input | PORTS*CLIENTS*ADDR_W | Byte address per client |
| reqWdata | input | PORTS*CLIENTS*128 | Write or swap data per client |
| reqBe | input | PORTS*CLIENTS*16 | Byte enables per client |
| reqCmp | input | PORTS*CLIENTS*128 | Compare word per client |
| rspValid | output | PORTS | Response valid per port |
| rspClient | output | PORTS*CID_W | Client index of the response |
| rspErr | output | PORTS | Address out of range |
| rspData | output | PORTS*128 | Response data |

## Verification
The hardest case to reach is a fair outcome that fixed priority would decide differently. The bench first issues a lone request so that a bank or client pointer moves away from index zero. It then starts two contenders in the same cycle and checks that the one after the pointer wins. The five-cycle hold is checked by starting a second request in the cycle right after a read-modify-write and counting the cycles until it is accepted, once on the same port and once on the same bank from another port.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [2:0] {
    OP_READ   = 3'd0,
    OP_WRITE  = 3'd1,
    OP_NREAD  = 3'd2,
    OP_NWRITE = 3'd3,
    OP_SWAP   = 3'd4,
    OP_CAS    = 3'd5
  } spOp_e;

  // per-port strobes from control to datapath
  typedef struct packed {
    logic fire;
    logic err;
  } portStb_t;

  // per-bank strobes for the read-modify-write sequence
  typedef struct packed {
    logic start;
    logic commit;
  } bankStb_t;

  function automatic logic opIsRmw(logic [2:0] op);
    return (op == OP_NWRITE) || (op == OP_SWAP) || (op == OP_CAS);
  endfunction

  function automatic logic [127:0] byteMask(logic [15:0] be);
    logic [127:0] m;
    for (int i = 0; i < 16; i++) m[i*8 +: 8] = {8{be[i]}};
    return m;
  endfunction
endpackage

// File: rtl/sp_ctrl.sv
module sp_ctrl
  import sp_pkg::*;
#(
  parameter int PORTS       = 3,
  parameter int CLIENTS     = 2,
  parameter int BANKS       = 16,
  parameter int BANK_DEPTH  = 4,
  parameter int ADDR_W      = 12,
  parameter int LOCK_CYCLES = 5,
  localparam int NREQ   = PORTS * CLIENTS,
  localparam int OFF_W  = 4,
  localparam int BANK_W = $clog2(BANKS),
  localparam int ROW_W  = ADDR_W - OFF_W - BANK_W,
  localparam int CID_W  = (CLIENTS > 1) ? $clog2(CLIENTS) : 1,
  localparam int PW     = (PORTS > 1) ? $clog2(PORTS) : 1
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [NREQ-1:0]                   reqValid,
  input  logic [NREQ-1:0][2:0]              reqOp,
  input  logic [NREQ-1:0][ADDR_W-1:0]       reqAddr,
  output logic [NREQ-1:0]                   reqReady,
  output logic [PORTS-1:0][CID_W-1:0]       selClient,
  output portStb_t [PORTS-1:0]              portStb,
  output bankStb_t [BANKS-1:0]              bankStb,
  output logic [BANKS-1:0][PW-1:0]          bankSrc
);
  localparam int LCW = $clog2(LOCK_CYCLES + 1);
  localparam logic [ROW_W:0] DEPTH_L = (ROW_W + 1)'(BANK_DEPTH);
  localparam logic [LCW-1:0] LOCK_LOAD = LCW'(LOCK_CYCLES - 1);

  logic [PORTS-1:0][LCW-1:0]    portLock;
  logic [BANKS-1:0][LCW-1:0]    bankLock;
  logic [PORTS-1:0][CID_W-1:0]  cPtr;
  logic [BANKS-1:0][PW-1:0]     bPtr;
  logic [PORTS-1:0]             selValid, inRange, isRmw, eligible, fire;
  logic [PORTS-1:0][BANK_W-1:0] selBank;
  logic [BANKS-1:0][PORTS-1:0]  bankGrant;

  // client multiplexer per port, round-robin from cPtr
  always_comb begin
    for (int p = 0; p < PORTS; p++) begin
      selValid[p]  = 1'b0;
      selClient[p] = '0;
      for (int i = 0; i < CLIENTS; i++) begin
        if (!selValid[p] && reqValid[p*CLIENTS + (int'(cPtr[p]) + i) % CLIENTS]) begin
          selValid[p]  = 1'b1;
          selClient[p] = CID_W'((int'(cPtr[p]) + i) % CLIENTS);
        end
      end
      selBank[p]  = reqAddr[p*CLIENTS + int'(selClient[p])][OFF_W +: BANK_W];
      inRange[p]  = {1'b0, reqAddr[p*CLIENTS + int'(selClient[p])][ADDR_W-1 -: ROW_W]} < DEPTH_L;
      isRmw[p]    = opIsRmw(reqOp[p*CLIENTS + int'(selClient[p])]);
      eligible[p] = selValid[p] && (portLock[p] == '0);
    end
  end

  // per-bank round-robin among ports
  always_comb begin
    for (int b = 0; b < BANKS; b++) begin
      bankGrant[b] = '0;
      bankSrc[b]   = '0;
      for (int i = 0; i < PORTS; i++) begin
        if (bankGrant[b] == '0 && bankLock[b] == '0
            && eligible[(int'(bPtr[b]) + i) % PORTS]
            && inRange[(int'(bPtr[b]) + i) % PORTS]
            && selBank[(int'(bPtr[b]) + i) % PORTS] == BANK_W'(b)) begin
          bankGrant[b][(int'(bPtr[b]) + i) % PORTS] = 1'b1;
          bankSrc[b] = PW'((int'(bPtr[b]) + i) % PORTS);
        end
      end
      bankStb[b].start  = |(bankGrant[b] & isRmw);
      bankStb[b].commit = (bankLock[b] == LCW'(1));
    end
  end

  always_comb begin
    for (int p = 0; p < PORTS; p++) begin
      fire[p] = eligible[p] && !inRange[p];
      for (int b = 0; b < BANKS; b++) fire[p] = fire[p] | bankGrant[b][p];
      portStb[p].fire = fire[p];
      portStb[p].err  = !inRange[p];
      for (int c = 0; c < CLIENTS; c++)
        reqReady[p*CLIENTS + c] = fire[p] && (selClient[p] == CID_W'(c));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      portLock <= '0;
      bankLock <= '0;
      cPtr     <= '0;
      bPtr     <= '0;
    end else begin
      for (int p = 0; p < PORTS; p++) begin
        if (fire[p]) cPtr[p] <= CID_W'((int'(selClient[p]) + 1) % CLIENTS);
        if (fire[p] && inRange[p] && isRmw[p]) portLock[p] <= LOCK_LOAD;
        else if (portLock[p] != '0)            portLock[p] <= portLock[p] - 1'b1;
      end
      for (int b = 0; b < BANKS; b++) begin
        if (bankGrant[b] != '0) bPtr[b] <= PW'((int'(bankSrc[b]) + 1) % PORTS);
        if (bankStb[b].start)        bankLock[b] <= LOCK_LOAD;
        else if (bankLock[b] != '0)  bankLock[b] <= bankLock[b] - 1'b1;
      end
    end
  end
endmodule

// File: rtl/sp_datapath.sv
module sp_datapath
  import sp_pkg::*;
#(
  parameter int PORTS      = 3,
  parameter int CLIENTS    = 2,
  parameter int BANKS      = 16,
  parameter int BANK_DEPTH = 4,
  parameter int ADDR_W     = 12,
  localparam int NREQ   = PORTS * CLIENTS,
  localparam int OFF_W  = 4,
  localparam int BANK_W = $clog2(BANKS),
  localparam int RIX_W  = (BANK_DEPTH > 1) ? $clog2(BANK_DEPTH) : 1,
  localparam int CID_W  = (CLIENTS > 1) ? $clog2(CLIENTS) : 1,
  localparam int PW     = (PORTS > 1) ? $clog2(PORTS) : 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NREQ-1:0][2:0]         reqOp,
  input  logic [NREQ-1:0][ADDR_W-1:0]  reqAddr,
  input  logic [NREQ-1:0][127:0]       reqWdata,
  input  logic [NREQ-1:0][15:0]        reqBe,
  input  logic [NREQ-1:0][127:0]       reqCmp,
  input  logic [PORTS-1:0][CID_W-1:0]  selClient,
  input  portStb_t [PORTS-1:0]         portStb,
  input  bankStb_t [BANKS-1:0]         bankStb,
  input  logic [BANKS-1:0][PW-1:0]     bankSrc,
  output logic [PORTS-1:0]             rspValid,
  output logic [PORTS-1:0][CID_W-1:0]  rspClient,
  output logic [PORTS-1:0]             rspErr,
  output logic [PORTS-1:0][127:0]      rspData
);
  logic [127:0] mem [BANKS][BANK_DEPTH];

  logic [PORTS-1:0][2:0]        mOp;
  logic [PORTS-1:0][BANK_W-1:0] mBank;
  logic [PORTS-1:0][RIX_W-1:0]  mRow;
  logic [PORTS-1:0][127:0]      mWdata, mCmp;
  logic [PORTS-1:0][15:0]       mBe;

  logic [BANKS-1:0][RIX_W-1:0] hRow;
  logic [BANKS-1:0][2:0]       hOp;
  logic [BANKS-1:0][15:0]      hBe;
  logic [BANKS-1:0][127:0]     hWdata, hCmp, hOld, newWord;

  always_comb begin
    for (int p = 0; p < PORTS; p++) begin
      mOp[p]    = reqOp[p*CLIENTS + int'(selClient[p])];
      mBank[p]  = reqAddr[p*CLIENTS + int'(selClient[p])][OFF_W +: BANK_W];
      mRow[p]   = reqAddr[p*CLIENTS + int'(selClient[p])][OFF_W + BANK_W +: RIX_W];
      mWdata[p] = reqWdata[p*CLIENTS + int'(selClient[p])];
      mCmp[p]   = reqCmp[p*CLIENTS + int'(selClient[p])];
      mBe[p]    = reqBe[p*CLIENTS + int'(selClient[p])];
    end
  end

  // merge stage of the read-modify-write
  always_comb begin
    for (int b = 0; b < BANKS; b++) begin
      unique case (hOp[b])
        OP_NWRITE: newWord[b] = (hOld[b] & ~byteMask(hBe[b])) | (hWdata[b] & byteMask(hBe[b]));
        OP_SWAP:   newWord[b] = hWdata[b];
        OP_CAS:    newWord[b] = (hOld[b] == hCmp[b]) ? hWdata[b] : hOld[b];
        default:   newWord[b] = hOld[b];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid  <= '0;
      rspErr    <= '0;
      rspClient <= '0;
      rspData   <= '0;
    end else begin
      for (int p = 0; p < PORTS; p++) begin
        rspValid[p]  <= portStb[p].fire;
        rspErr[p]    <= portStb[p].fire && portStb[p].err;
        rspClient[p] <= selClient[p];
        rspData[p]   <= '0;
        if (portStb[p].fire && !portStb[p].err) begin
          unique case (mOp[p])
            OP_READ, OP_SWAP, OP_CAS: rspData[p] <= mem[mBank[p]][mRow[p]];
            OP_NREAD: rspData[p] <= mem[mBank[p]][mRow[p]] & byteMask(mBe[p]);
            default:  rspData[p] <= '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < PORTS; p++)
      if (portStb[p].fire && !portStb[p].err && mOp[p] == OP_WRITE)
        mem[mBank[p]][mRow[p]] <= mWdata[p];
    for (int b = 0; b < BANKS; b++) begin
      if (bankStb[b].start) begin
        hRow[b]   <= mRow[bankSrc[b]];
        hOp[b]    <= mOp[bankSrc[b]];
        hBe[b]    <= mBe[bankSrc[b]];
        hWdata[b] <= mWdata[bankSrc[b]];
        hCmp[b]   <= mCmp[bankSrc[b]];
        hOld[b]   <= mem[b][mRow[bankSrc[b]]];
      end
      if (bankStb[b].commit) mem[b][hRow[b]] <= newWord[b];
    end
  end
endmodule

// File: rtl/sp_banked_scratch.sv
module sp_banked_scratch
  import sp_pkg::*;
#(
  parameter int PORTS       = 3,
  parameter int CLIENTS     = 2,
  parameter int BANKS       = 16,
  parameter int BANK_DEPTH  = 4,
  parameter int ADDR_W      = 12,
  parameter int LOCK_CYCLES = 5,
  localparam int NREQ  = PORTS * CLIENTS,
  localparam int CID_W = (CLIENTS > 1) ? $clog2(CLIENTS) : 1,
  localparam int PW    = (PORTS > 1) ? $clog2(PORTS) : 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NREQ-1:0]              reqValid,
  output logic [NREQ-1:0]              reqReady,
  input  logic [NREQ-1:0][2:0]         reqOp,
  input  logic [NREQ-1:0][ADDR_W-1:0]  reqAddr,
  input  logic [NREQ-1:0][127:0]       reqWdata,
  input  logic [NREQ-1:0][15:0]        reqBe,
  input  logic [NREQ-1:0][127:0]       reqCmp,
  output logic [PORTS-1:0]             rspValid,
  output logic [PORTS-1:0][CID_W-1:0]  rspClient,
  output logic [PORTS-1:0]             rspErr,
  output logic [PORTS-1:0][127:0]      rspData
);
  logic [PORTS-1:0][CID_W-1:0] selClient;
  portStb_t [PORTS-1:0]        portStb;
  bankStb_t [BANKS-1:0]        bankStb;
  logic [BANKS-1:0][PW-1:0]    bankSrc;

  sp_ctrl #(.PORTS(PORTS), .CLIENTS(CLIENTS), .BANKS(BANKS), .BANK_DEPTH(BANK_DEPTH),
            .ADDR_W(ADDR_W), .LOCK_CYCLES(LOCK_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqReady(reqReady), .selClient(selClient), .portStb(portStb),
    .bankStb(bankStb), .bankSrc(bankSrc)
  );

  sp_datapath #(.PORTS(PORTS), .CLIENTS(CLIENTS), .BANKS(BANKS), .BANK_DEPTH(BANK_DEPTH),
                .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .reqOp(reqOp), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqBe(reqBe), .reqCmp(reqCmp), .selClient(selClient), .portStb(portStb),
    .bankStb(bankStb), .bankSrc(bankSrc), .rspValid(rspValid), .rspClient(rspClient),
    .rspErr(rspErr), .rspData(rspData)
  );
endmodule

// File: rtl/sp_checker.sv
module sp_checker #(
  parameter int PORTS       = 3,
  parameter int CLIENTS     = 2,
  parameter int BANKS       = 16,
  parameter int BANK_DEPTH  = 4,
  parameter int ADDR_W      = 12,
  parameter int LOCK_CYCLES = 5,
  localparam int NREQ   = PORTS * CLIENTS,
  localparam int BANK_W = $clog2(BANKS),
  localparam int ROW_W  = ADDR_W - 4 - BANK_W,
  localparam int CID_W  = (CLIENTS > 1) ? $clog2(CLIENTS) : 1,
  localparam int LCW    = $clog2(LOCK_CYCLES + 1)
) (
  input logic                         clk,
  input logic                         rstN,
  input logic [NREQ-1:0]              reqValid,
  input logic [NREQ-1:0]              reqReady,
  input logic [NREQ-1:0][2:0]         reqOp,
  input logic [NREQ-1:0][ADDR_W-1:0]  reqAddr,
  input logic [PORTS-1:0]             rspValid,
  input logic [PORTS-1:0][CID_W-1:0]  rspClient,
  input logic [PORTS-1:0]             rspErr
);
  logic [PORTS-1:0]             acc, inr, rmw;
  logic [PORTS-1:0][BANK_W-1:0] bnk;
  logic [PORTS-1:0][LCW-1:0]    win;

  always_comb begin
    for (int p = 0; p < PORTS; p++) begin
      acc[p] = 1'b0; inr[p] = 1'b0; rmw[p] = 1'b0; bnk[p] = '0;
      for (int c = 0; c < CLIENTS; c++) begin
        if (reqValid[p*CLIENTS+c] && reqReady[p*CLIENTS+c]) begin
          acc[p] = 1'b1;
          bnk[p] = reqAddr[p*CLIENTS+c][4 +: BANK_W];
          inr[p] = int'(reqAddr[p*CLIENTS+c][ADDR_W-1 -: ROW_W]) < BANK_DEPTH;
          rmw[p] = reqOp[p*CLIENTS+c] inside {3'd3, 3'd4, 3'd5};
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < PORTS; p++) begin
      if (!rstN) win[p] <= '0;
      else if (acc[p] && inr[p] && rmw[p]) win[p] <= LCW'(LOCK_CYCLES - 1);
      else if (win[p] != '0) win[p] <= win[p] - 1'b1;
    end
  end

  for (genvar k = 0; k < NREQ; k++) begin : g_req
    AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rstN)
      (reqValid[k] && reqReady[k]) |=> (rspValid[k/CLIENTS] && rspClient[k/CLIENTS] == CID_W'(k % CLIENTS))); // R5
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    AST_ONE_CLIENT: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(reqReady[p*CLIENTS +: CLIENTS])); // R3
    AST_PORT_HELD: assert property (@(posedge clk) disable iff (!rstN)
      (win[p] != '0) |-> (reqReady[p*CLIENTS +: CLIENTS] == '0)); // R8
    AST_ERR_FLAG: assert property (@(posedge clk) disable iff (!rstN)
      acc[p] |=> (rspErr[p] == !$past(inr[p]))); // R11
    for (genvar q = p + 1; q < PORTS; q++) begin : g_pair
      AST_BANK_EXCL: assert property (@(posedge clk) disable iff (!rstN)
        (acc[p] && acc[q] && inr[p] && inr[q]) |-> (bnk[p] != bnk[q])); // R2
    end
  end
endmodule

bind sp_banked_scratch sp_checker #(
  .PORTS(PORTS), .CLIENTS(CLIENTS), .BANKS(BANKS), .BANK_DEPTH(BANK_DEPTH),
  .ADDR_W(ADDR_W), .LOCK_CYCLES(LOCK_CYCLES)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqOp(reqOp),
  .reqAddr(reqAddr), .rspValid(rspValid), .rspClient(rspClient), .rspErr(rspErr)
);

// File: tb/sp_banked_scratch_tb.sv
`timescale 1ns/1ps
module sp_banked_scratch_tb;
  localparam int PORTS = 3, CLIENTS = 2, NREQ = PORTS * CLIENTS;

  logic clk = 1'b0, rstN = 1'b0;
  logic [NREQ-1:0] reqValid = '0, reqReady;
  logic [NREQ-1:0][2:0] reqOp = '0;
  logic [NREQ-1:0][11:0] reqAddr = '0;
  logic [NREQ-1:0][127:0] reqWdata = '0, reqCmp = '0;
  logic [NREQ-1:0][15:0] reqBe = '0;
  logic [PORTS-1:0] rspValid, rspErr;
  logic [PORTS-1:0][0:0] rspClient;
  logic [PORTS-1:0][127:0] rspData;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sp_banked_scratch u_dut (.*);

  localparam logic [127:0] WA = 128'h00112233_44556677_8899AABB_CCDDEEFF;
  localparam logic [127:0] WB = {4{32'hDEADBEEF}};
  localparam logic [127:0] WC = {4{32'h0F1E2D3C}};
  localparam logic [127:0] WA_M = 128'h00112233_44556677_8899AABB_00000000;

  typedef struct packed {
    logic [3:0]   rq;
    logic [2:0]   op;
    logic [11:0]  addr;
    logic [15:0]  be;
    logic [127:0] wd;
    logic [127:0] cmp;
    logic [127:0] exp;
    logic         err;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{4'd6,  3'd1, 12'h010, 16'h0000, WA, '0, '0, 1'b0},           // R6 write ignores be
    '{4'd6,  3'd0, 12'h010, 16'h0000, '0, '0, WA, 1'b0},           // R6 read whole word
    '{4'd7,  3'd2, 12'h010, 16'h00FF, '0, '0, 128'h8899AABB_CCDDEEFF, 1'b0}, // R7
    '{4'd1,  3'd1, 12'h020, 16'hFFFF, WB, '0, '0, 1'b0},           // R1
    '{4'd1,  3'd1, 12'h120, 16'hFFFF, WC, '0, '0, 1'b0},           // R1 other row
    '{4'd1,  3'd0, 12'h020, 16'h0000, '0, '0, WB, 1'b0},           // R1
    '{4'd1,  3'd0, 12'h120, 16'h0000, '0, '0, WC, 1'b0},           // R1
    '{4'd8,  3'd3, 12'h010, 16'h000F, '0, '0, '0, 1'b0},           // R8 narrow write
    '{4'd8,  3'd0, 12'h010, 16'h0000, '0, '0, WA_M, 1'b0},         // R8 merged
    '{4'd9,  3'd4, 12'h020, 16'h0000, WC, '0, WB, 1'b0},           // R9 swap
    '{4'd9,  3'd0, 12'h020, 16'h0000, '0, '0, WC, 1'b0},           // R9
    '{4'd10, 3'd5, 12'h020, 16'h0000, WA, WB, WC, 1'b0},           // R10 miss
    '{4'd10, 3'd0, 12'h020, 16'h0000, '0, '0, WC, 1'b0},           // R10 unchanged
    '{4'd10, 3'd5, 12'h020, 16'h0000, WA, WC, WC, 1'b0},           // R10 hit
    '{4'd10, 3'd0, 12'h020, 16'h0000, '0, '0, WA, 1'b0},           // R10 stored
    '{4'd11, 3'd0, 12'h400, 16'h0000, '0, '0, '0, 1'b1},           // R11
    '{4'd11, 3'd1, 12'h410, 16'hFFFF, WB, '0, '0, 1'b1},           // R11
    '{4'd11, 3'd0, 12'h010, 16'h0000, '0, '0, WA_M, 1'b0}          // R11 storage intact
  };

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge where the response is visible
  task automatic doReq(input int k, input logic [2:0] op, input logic [11:0] addr,
                       input logic [127:0] wd, input logic [15:0] be, input logic [127:0] cmp,
                       output logic [127:0] data, output logic err, output int waits);
    reqOp[k] = op; reqAddr[k] = addr; reqWdata[k] = wd; reqBe[k] = be; reqCmp[k] = cmp;
    reqValid[k] = 1'b1;
    waits = 0;
    #1;
    while (!reqReady[k] && waits < 50) begin
      @(negedge clk); #1; waits++;
    end
    @(negedge clk);
    reqValid[k] = 1'b0;
    chk("R5 rspValid", {127'd0, rspValid[k/CLIENTS]}, 128'd1);
    chk("R5 rspClient", {127'd0, rspClient[k/CLIENTS]}, 128'(k % CLIENTS));
    data = rspData[k/CLIENTS];
    err = rspErr[k/CLIENTS];
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [127:0] d, d2;
    logic e, e2;
    int w, w2;
    repeat (3) @(negedge clk);
    chk("R5 reset rspValid", {125'd0, rspValid}, '0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R2 reset ready", {122'd0, reqReady}, '0);

    for (int i = 0; i < NV; i++) begin
      doReq(0, VEC[i].op, VEC[i].addr, VEC[i].wd, VEC[i].be, VEC[i].cmp, d, e, w);
      chk($sformatf("R%0d vec%0d data", VEC[i].rq, i), d, VEC[i].exp);
      chk($sformatf("R%0d vec%0d err", VEC[i].rq, i), {127'd0, e}, {127'd0, VEC[i].err});
    end

    // R8 port hold: same port, other bank, right after a narrow write
    doReq(0, 3'd1, 12'h050, '0, 16'hFFFF, '0, d, e, w);
    doReq(0, 3'd3, 12'h050, {16{8'h11}}, 16'h0003, '0, d, e, w);
    doReq(0, 3'd0, 12'h060, '0, '0, '0, d, e, w);
    chk("R8 port held cycles", 128'(w), 128'd4);
    // R8 bank hold: other port, same bank
    doReq(0, 3'd3, 12'h050, {16{8'h22}}, 16'h000C, '0, d, e, w);
    doReq(2, 3'd0, 12'h050, '0, '0, '0, d, e, w);
    chk("R8 bank held cycles", 128'(w), 128'd4);
    chk("R8 merged bytes", d, 128'h22221111);
    // R7 narrow read frees the port at once
    doReq(0, 3'd2, 12'h050, '0, 16'h0001, '0, d, e, w);
    chk("R7 narrow data", d, 128'h11);
    doReq(0, 3'd0, 12'h060, '0, '0, '0, d, e, w);
    chk("R7 no hold", 128'(w), 128'd0);

    // R2 two ports on one bank
    doReq(0, 3'd1, 12'h070, WB, 16'hFFFF, '0, d, e, w);
    fork
      doReq(0, 3'd0, 12'h070, '0, '0, '0, d, e, w);
      doReq(2, 3'd0, 12'h070, '0, '0, '0, d2, e2, w2);
    join
    chk("R2 one loser", 128'(w + w2), 128'd1);
    chk("R2 data port0", d, WB);
    chk("R2 data port1", d2, WB);

    // R4 bank pointer moved to port 2 by a lone port-1 access
    doReq(2, 3'd0, 12'h090, '0, '0, '0, d, e, w);
    fork
      doReq(0, 3'd0, 12'h090, '0, '0, '0, d, e, w);
      doReq(4, 3'd0, 12'h090, '0, '0, '0, d2, e2, w2);
    join
    chk("R4 port2 first", 128'(w2), 128'd0);
    chk("R4 port0 second", 128'(w), 128'd1);

    // R3 client pointer moved to client 1 by a lone client-0 access
    doReq(4, 3'd0, 12'h0A0, '0, '0, '0, d, e, w);
    fork
      doReq(4, 3'd0, 12'h0B0, '0, '0, '0, d, e, w);
      doReq(5, 3'd0, 12'h0C0, '0, '0, '0, d2, e2, w2);
    join
    chk("R3 client1 first", 128'(w2), 128'd0);
    chk("R3 client0 second", 128'(w), 128'd1);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule